// File: doc/BRIEF.md
# USB End-of-Packet Detector

This block watches the decoded single-ended state of a USB line, one sample per clock of the oversampling clock, and decides when a packet has ended. It measures the length of every single-ended-zero (SE0) run against a minimum that depends on the selected speed. When a run long enough to count as an end of packet is left, the block issues a one-clock end-of-packet pulse. The pulse is issued whether the line goes to J, as it should, or to some other state. In the second case it also raises a possible-bad-EOP flag, so a receiver can still close the current packet and be ready for the next one.

A speed-select input picks the full-speed or the low-speed length rule and the set of run states used to follow the SE0. The 3-bit machine state is brought out as a port so it can be seen while debugging. Synchronizing the raw line and decoding packets are handled elsewhere.

Top module: `usb_eop_detector`

## Requirements
- R1: After reset the debug state reads 000 and both the end-of-packet pulse and the bad flag are low.
- R2: The line input uses 00 = SE0, 01 = J, 10 = K, 11 = SE1. At full speed (lowSpeed = 0) the samples of an SE0 run show debug state 100 for the first sample, 010 for the second, and 110 for the third and every later one.
- R3: At low speed (lowSpeed = 1) the samples of an SE0 run show debug state 101 for the first sample and 011 for the second and every later one.
- R4: At full speed an SE0 run qualifies once it has at least ceil(60 ns / sample period) samples (3 at the default 48 MHz). A qualifying run followed by J gives debug state 001 with the pulse high and the bad flag low.
- R5: At low speed an SE0 run qualifies once it has at least ceil(300 ns / sample period) samples (15 at the default).
- R6: A qualifying run followed by K or SE1 gives debug state 111 with both the pulse and the bad flag high.
- R7: An SE0 run shorter than its minimum that ends in J, K or SE1 sends the state to 000 with no pulse and no flag.
- R8: From 001 or 111 the state returns to 000 on the next sample whatever the line shows, and an SE0 in that sample does not count towards a new run.
- R9: The pulse and the flag last exactly one clock, and J or K while idle leaves the state at 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowSpeed | input | 1 | 1 selects the low-speed SE0 rule and states |
| lineState | input | 2 | Sampled line: 00 SE0, 01 J, 10 K, 11 SE1 |
| eopPulse | output | 1 | One-clock end-of-packet strobe |
| badEopFlag | output | 1 | One-clock flag: the end of packet was not followed by J |
| stateDbg | output | 3 | Current machine state encoding |

## Verification
The checker watches, on every cycle, that the pulse and flag are single-clock and that the flag never shows without the pulse. It also checks that the end states always fall back to idle, that an SE0 run state is never entered except on an SE0 sample, and that the valid end state is never entered except on a J sample. Only the bench's scenarios can show that the run-length thresholds fall at exactly the right sample count for each speed, that the exact run-state encodings appear in order, and that an SE0 arriving during the end state is not counted. The bench covers these by sweeping every run length up to past the low-speed minimum, across both speeds and all three exit states.

// File: rtl/usb_eop_pkg.sv
package usb_eop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'b000,
    ST_FS_SE0_A  = 3'b100,
    ST_FS_SE0_B  = 3'b010,
    ST_FS_SE0_C  = 3'b110,
    ST_EOP_OK    = 3'b001,
    ST_LS_SE0_A  = 3'b101,
    ST_LS_SE0_B  = 3'b011,
    ST_EOP_BAD   = 3'b111
  } eopState_t;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
  localparam logic [1:0] LINE_SE1 = 2'b11;

  typedef struct packed {
    logic runStep;
    logic runClear;
  } eopCtl_t;

endpackage

// File: rtl/eop_run_datapath.sv
module eop_run_datapath
  import usb_eop_pkg::*;
#(
  parameter int FS_MIN = 3,
  parameter int LS_MIN = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowSpeed,
  input  logic [1:0] lineState,
  input  eopCtl_t    ctl,
  output logic       isSe0,
  output logic       isJ,
  output logic       runQualified
);

  localparam int MAX_MIN = (FS_MIN > LS_MIN) ? FS_MIN : LS_MIN;
  localparam int CNT_W   = $clog2(MAX_MIN + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FS_LIM  = CNT_W'(FS_MIN);
  localparam logic [CNT_W-1:0] LS_LIM  = CNT_W'(LS_MIN);

  logic [CNT_W-1:0] runLen;

  assign isSe0 = (lineState == LINE_SE0);
  assign isJ   = (lineState == LINE_J);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (ctl.runClear) begin
      runLen <= '0;
    end else if (ctl.runStep && (runLen != CNT_SAT)) begin
      runLen <= runLen + 1'b1;
    end
  end

  assign runQualified = lowSpeed ? (runLen >= LS_LIM) : (runLen >= FS_LIM);

endmodule

// File: rtl/eop_state_ctrl.sv
module eop_state_ctrl
  import usb_eop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lowSpeed,
  input  logic      isSe0,
  input  logic      isJ,
  input  logic      runQualified,
  output eopState_t state,
  output eopCtl_t   ctl
);

  eopState_t nextState;
  eopState_t exitState;

  always_comb begin
    if (!runQualified)  exitState = ST_IDLE;
    else if (isJ)       exitState = ST_EOP_OK;
    else                exitState = ST_EOP_BAD;
  end

  always_comb begin
    nextState = ST_IDLE;
    case (state)
      ST_IDLE:     nextState = isSe0 ? (lowSpeed ? ST_LS_SE0_A : ST_FS_SE0_A) : ST_IDLE;
      ST_FS_SE0_A: nextState = isSe0 ? ST_FS_SE0_B : exitState;
      ST_FS_SE0_B: nextState = isSe0 ? ST_FS_SE0_C : exitState;
      ST_FS_SE0_C: nextState = isSe0 ? ST_FS_SE0_C : exitState;
      ST_LS_SE0_A: nextState = isSe0 ? ST_LS_SE0_B : exitState;
      ST_LS_SE0_B: nextState = isSe0 ? ST_LS_SE0_B : exitState;
      ST_EOP_OK:   nextState = ST_IDLE;
      ST_EOP_BAD:  nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.runStep  = (nextState == ST_FS_SE0_A) || (nextState == ST_FS_SE0_B) ||
                   (nextState == ST_FS_SE0_C) || (nextState == ST_LS_SE0_A) ||
                   (nextState == ST_LS_SE0_B);
    ctl.runClear = !ctl.runStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/usb_eop_detector.sv
module usb_eop_detector
  import usb_eop_pkg::*;
#(
  parameter int SAMPLE_PERIOD_PS = 20833,
  parameter int FS_SE0_MIN_PS    = 60000,
  parameter int LS_SE0_MIN_PS    = 300000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowSpeed,
  input  logic [1:0] lineState,
  output logic       eopPulse,
  output logic       badEopFlag,
  output logic [2:0] stateDbg
);

  localparam int FS_RAW = (FS_SE0_MIN_PS + SAMPLE_PERIOD_PS - 1) / SAMPLE_PERIOD_PS;
  localparam int LS_RAW = (LS_SE0_MIN_PS + SAMPLE_PERIOD_PS - 1) / SAMPLE_PERIOD_PS;
  localparam int FS_MIN = (FS_RAW < 1) ? 1 : FS_RAW;
  localparam int LS_MIN = (LS_RAW < 1) ? 1 : LS_RAW;

  eopCtl_t   ctl;
  eopState_t state;
  logic      isSe0;
  logic      isJ;
  logic      runQualified;

  eop_run_datapath #(
    .FS_MIN(FS_MIN),
    .LS_MIN(LS_MIN)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .lowSpeed    (lowSpeed),
    .lineState   (lineState),
    .ctl         (ctl),
    .isSe0       (isSe0),
    .isJ         (isJ),
    .runQualified(runQualified)
  );

  eop_state_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lowSpeed    (lowSpeed),
    .isSe0       (isSe0),
    .isJ         (isJ),
    .runQualified(runQualified),
    .state       (state),
    .ctl         (ctl)
  );

  assign stateDbg   = state;
  assign eopPulse   = (state == ST_EOP_OK) || (state == ST_EOP_BAD);
  assign badEopFlag = (state == ST_EOP_BAD);

endmodule

// File: rtl/usb_eop_checker.sv
module usb_eop_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] lineState,
  input logic       eopPulse,
  input logic       badEopFlag,
  input logic [2:0] stateDbg
);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |=> !eopPulse);

  assert_flag_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    badEopFlag |=> !badEopFlag);

  assert_flag_with_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    badEopFlag |-> eopPulse);

  assert_end_to_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateDbg == 3'b001 || stateDbg == 3'b111) |=> (stateDbg == 3'b000));

  assert_run_needs_se0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineState != 2'b00) |=> !(stateDbg == 3'b100 || stateDbg == 3'b010 ||
      stateDbg == 3'b110 || stateDbg == 3'b101 || stateDbg == 3'b011));

  assert_ok_needs_j_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lineState != 2'b01) |=> (stateDbg != 3'b001));

  assert_bad_needs_nonj_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == 2'b01 || lineState == 2'b00) |=> (stateDbg != 3'b111));

endmodule

bind usb_eop_detector usb_eop_checker uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .lineState (lineState),
  .eopPulse  (eopPulse),
  .badEopFlag(badEopFlag),
  .stateDbg  (stateDbg)
);

// File: tb/tb_usb_eop_detector.sv
module tb_usb_eop_detector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lowSpeed = 1'b0;
  logic [1:0] lineState = 2'b01;
  logic       eopPulse;
  logic       badEopFlag;
  logic [2:0] stateDbg;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int PERIOD_PS = 20833;
  localparam int FS_N = (60000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int LS_N = (300000 + PERIOD_PS - 1) / PERIOD_PS;

  always #2.5 clk = ~clk;

  usb_eop_detector dut (
    .clk       (clk),
    .rstN      (rstN),
    .lowSpeed  (lowSpeed),
    .lineState (lineState),
    .eopPulse  (eopPulse),
    .badEopFlag(badEopFlag),
    .stateDbg  (stateDbg)
  );

  task automatic checkOut(input string req, input logic [2:0] expState,
                          input logic expPulse, input logic expBad);
    checks++;
    if (stateDbg !== expState || eopPulse !== expPulse || badEopFlag !== expBad) begin
      errors++;
      $display("FAIL %s: state/pulse/bad got %b/%b/%b expected %b/%b/%b",
               req, stateDbg, eopPulse, badEopFlag, expState, expPulse, expBad);
    end
  endtask

  task automatic drive(input logic [1:0] v);
    lineState = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] runState(input bit ls, input int i);
    if (ls) return (i == 1) ? 3'b101 : 3'b011;
    if (i == 1) return 3'b100;
    if (i == 2) return 3'b010;
    return 3'b110;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 reset", 3'b000, 1'b0, 1'b0);
    rstN = 1'b1;
    drive(2'b01); checkOut("R9 idle J", 3'b000, 1'b0, 1'b0);
    drive(2'b10); checkOut("R9 idle K", 3'b000, 1'b0, 1'b0);
    drive(2'b01); checkOut("R9 idle J", 3'b000, 1'b0, 1'b0);

    for (int sp = 0; sp < 2; sp++) begin
      for (int len = 1; len <= LS_N + 3; len++) begin
        for (int ex = 0; ex < 3; ex++) begin
          logic [1:0] exitCode;
          int minLen;
          bit qual;
          exitCode = (ex == 0) ? 2'b01 : (ex == 1) ? 2'b10 : 2'b11;
          minLen = sp ? LS_N : FS_N;
          qual = (len >= minLen);
          lowSpeed = sp[0];
          drive(2'b01);
          checkOut("R9 idle before run", 3'b000, 1'b0, 1'b0);
          for (int i = 1; i <= len; i++) begin
            drive(2'b00);
            checkOut(sp ? "R3 slow run state" : "R2 full run state",
                     runState(sp[0], i), 1'b0, 1'b0);
          end
          drive(exitCode);
          if (!qual)
            checkOut("R7 short SE0", 3'b000, 1'b0, 1'b0);
          else if (ex == 0)
            checkOut(sp ? "R5 slow valid end" : "R4 full valid end", 3'b001, 1'b1, 1'b0);
          else
            checkOut("R6 bad end", 3'b111, 1'b1, 1'b1);
          if (qual && ex == 0) begin
            drive(2'b00);
            checkOut("R8 SE0 in end state ignored", 3'b000, 1'b0, 1'b0);
            for (int i = 1; i <= minLen - 1; i++) begin
              drive(2'b00);
              checkOut("R8 fresh run", runState(sp[0], i), 1'b0, 1'b0);
            end
            drive(2'b01);
            checkOut("R8 uncounted sample", 3'b000, 1'b0, 1'b0);
          end else begin
            drive(2'b01);
            checkOut("R9 one clock wide", 3'b000, 1'b0, 1'b0);
          end
        end
      end
    end

    rstN = 1'b0;
    drive(2'b01);
    checkOut("R1 reset again", 3'b000, 1'b0, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule